// File: doc/BRIEF.md
# Auxiliary Packet ECC Encoder

This block takes one auxiliary data packet from a host, adds BCH parity to it, and hands the protected packet to a downstream serializer at a frame-timing slot. The host fills a byte buffer with three header bytes and twenty-eight body bytes. The first body byte is a checksum that the host has already computed without the parity bytes. The block never changes any host byte. It splits the body into four subpackets of seven bytes each and computes one parity byte per subpacket. It computes one more parity byte over the three header bytes.

The host first writes its bytes through a valid/ready write port, then pulses `arm`. From that point the block reports `busy`, and it refuses all writes and arms until the packet has been handed off. When the frame-timing strobe `vsync_strobe` is sampled while a packet is armed, the block freezes the header word and the four subpacket words into output registers and raises `out_valid`.

The output side follows valid/ready rules. While `out_valid` is high and `out_ready` is low, the words and `out_valid` hold steady. The transfer completes in the cycle where both are high. After that the block returns to idle and accepts a new load.

Top module: `aux_ecc_packer`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0, `wr_ready` is 1, and `out_hdr` and `out_sub` are all zeros.
- R2: A byte is stored when `wr_valid` and `wr_ready` are both high. Address 0 to 2 selects header bytes 0 to 2. Address 4 to 31 selects body bytes 0 to 27. Address 3, addresses 32 to 35 and any higher address have no effect on the packet.
- R3: `arm` sampled high while not busy makes `busy` read 1 from the next cycle on. `wr_ready` is always the inverse of `busy`.
- R4: While `busy` is 1, writes and further `arm` pulses are ignored, so the packet that goes out is the one present when it was armed.
- R5: `out_valid` rises in the cycle after `vsync_strobe` is sampled high while armed. A strobe sampled while idle, or in the same cycle as the `arm` that starts the load, releases nothing.
- R6: `out_hdr` bits 7:0, 15:8 and 23:16 hold header bytes 0, 1 and 2. Bits 31:24 hold the header parity.
- R7: Subpacket n (n = 0 to 3) sits in `out_sub[64n+63:64n]`. Its bits 8k+7:8k hold body byte 7n+k (k = 0 to 6), and bits 63:56 hold its parity. Body byte 0 (the checksum) appears unchanged in `out_sub[7:0]`.
- R8: Parity follows the generator x^8+x^7+x^6+1. An 8-bit state s starts at 0. Each data bit d is fed in order: byte order first, least significant bit first within a byte. For each bit, f = d XOR s[0], then s = (s >> 1) XOR (f ? 0x83 : 0). The parity byte is the final s.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_hdr` and `out_sub` hold their values. After a cycle with both high, `out_valid` and `busy` are 0 in the next cycle.
- R10: A header or subpacket whose data bytes are all zero gets parity 0x00. An all-ones packet gets the parity that the R8 rule gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Write can be accepted (not busy) |
| wr_addr | input | 6 | Byte slot in the 36-byte packet array |
| wr_data | input | 8 | Byte to store |
| arm | input | 1 | Pulse to lock the packet and wait for a slot |
| busy | output | 1 | Packet locked, waiting for a slot or a handoff |
| vsync_strobe | input | 1 | Frame-timing strobe that opens a packet slot |
| out_valid | output | 1 | Protected packet words are present |
| out_ready | input | 1 | Downstream takes the packet words |
| out_hdr | output | 32 | Header bytes plus header parity |
| out_sub | output | 256 | Four subpacket words, each seven bytes plus parity |

## Verification
Each result is due a fixed number of cycles after its stimulus. An accepted write shows up only in the next packet that is released. `busy` reads 1 one cycle after an accepted `arm`. `out_valid` and the parity-bearing words appear one cycle after the strobe is sampled. `busy` and `out_valid` drop one cycle after the handshake.

The bench keeps a behavioural model that updates on the rising edge from the same inputs the design sees. It drives inputs and compares all outputs on the falling edge, after every register on the path has taken its new value. Directed checks sample at exactly those offsets: the falling edge right after the strobe or handshake edge, and the falling edges of a held back-pressure window.

// File: rtl/aux_ecc_pkg.sv
package aux_ecc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_SEND  = 2'd2
  } seq_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/bch_par_net.sv
// Parallel form of a right-shifting Galois LFSR, fed least significant bit
// first; the loop unrolls into an XOR network evaluated in one cycle.
module bch_par_net #(
  parameter int DATA_BITS = 56,
  parameter int PAR_BITS  = 8,
  parameter logic [PAR_BITS-1:0] POLY_REFL = 8'h83
) (
  input  logic [DATA_BITS-1:0] data_i,
  output logic [PAR_BITS-1:0]  par_o
);

  logic [PAR_BITS-1:0] state_v;
  logic                fb_v;

  always_comb begin
    state_v = '0;
    fb_v    = 1'b0;
    for (int i = 0; i < DATA_BITS; i++) begin
      fb_v    = data_i[i] ^ state_v[0];
      state_v = (state_v >> 1) ^ (fb_v ? POLY_REFL : '0);
    end
    par_o = state_v;
  end

endmodule

// File: rtl/aux_pkt_buffer.sv
module aux_pkt_buffer
  import aux_ecc_pkg::*;
#(
  parameter int HDR_BYTES  = 3,
  parameter int HDR_SLOTS  = 4,
  parameter int BODY_BYTES = 28,
  parameter int ADDR_W     = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [BYTE_W-1:0]            data_i,
  output logic [HDR_BYTES*BYTE_W-1:0]  hdr_flat_o,
  output logic [BODY_BYTES*BYTE_W-1:0] body_flat_o
);

  logic [BYTE_W-1:0] hdr_q  [HDR_BYTES];
  logic [BYTE_W-1:0] body_q [BODY_BYTES];

  for (genvar h = 0; h < HDR_BYTES; h++) begin : g_hdr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hdr_q[h] <= '0;
      end else if (we_i && (addr_i == ADDR_W'(h))) begin
        hdr_q[h] <= data_i;
      end
    end
    assign hdr_flat_o[h*BYTE_W +: BYTE_W] = hdr_q[h];
  end

  for (genvar b = 0; b < BODY_BYTES; b++) begin : g_body
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        body_q[b] <= '0;
      end else if (we_i && (addr_i == ADDR_W'(HDR_SLOTS + b))) begin
        body_q[b] <= data_i;
      end
    end
    assign body_flat_o[b*BYTE_W +: BYTE_W] = body_q[b];
  end

endmodule

// File: rtl/aux_tx_seq.sv
module aux_tx_seq
  import aux_ecc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic slot_i,
  input  logic take_i,
  output logic busy_o,
  output logic capture_o,
  output logic valid_o
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (arm_i)  state_d = SEQ_ARMED;
      SEQ_ARMED: if (slot_i) state_d = SEQ_SEND;
      SEQ_SEND:  if (take_i) state_d = SEQ_IDLE;
      default:               state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign capture_o = (state_q == SEQ_ARMED) && slot_i;
  assign valid_o   = (state_q == SEQ_SEND);

endmodule

// File: rtl/aux_ecc_packer.sv
module aux_ecc_packer
  import aux_ecc_pkg::*;
#(
  parameter int HDR_BYTES = 3,
  parameter int SUB_COUNT = 4,
  parameter int SUB_BYTES = 7,
  parameter int PAR_BITS  = 8,
  parameter logic [PAR_BITS-1:0] POLY_REFL = 8'h83,
  localparam int HDR_SLOTS   = HDR_BYTES + 1,
  localparam int BODY_BYTES  = SUB_COUNT * SUB_BYTES,
  localparam int ARRAY_BYTES = HDR_SLOTS + BODY_BYTES + SUB_COUNT,
  localparam int ADDR_W      = $clog2(ARRAY_BYTES),
  localparam int HDR_DBITS   = HDR_BYTES * 8,
  localparam int SUB_DBITS   = SUB_BYTES * 8,
  localparam int HDR_W       = HDR_DBITS + PAR_BITS,
  localparam int SUB_W       = SUB_DBITS + PAR_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       arm,
  output logic                       busy,
  input  logic                       vsync_strobe,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [HDR_W-1:0]           out_hdr,
  output logic [SUB_COUNT*SUB_W-1:0] out_sub
);

  logic                  seq_busy;
  logic                  capture;
  logic                  seq_valid;
  logic                  wr_fire;
  logic                  arm_fire;
  logic [HDR_DBITS-1:0]  hdr_flat;
  logic [BODY_BYTES*BYTE_W-1:0] body_flat;
  logic [PAR_BITS-1:0]   hdr_par;
  logic [SUB_COUNT*SUB_W-1:0]   sub_word;
  logic [HDR_W-1:0]      hdr_q;
  logic [SUB_COUNT*SUB_W-1:0]   sub_q;

  assign wr_fire  = wr_valid && !seq_busy;
  assign arm_fire = arm && !seq_busy;

  aux_pkt_buffer #(
    .HDR_BYTES (HDR_BYTES),
    .HDR_SLOTS (HDR_SLOTS),
    .BODY_BYTES(BODY_BYTES),
    .ADDR_W    (ADDR_W)
  ) buf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (wr_fire),
    .addr_i     (wr_addr),
    .data_i     (wr_data),
    .hdr_flat_o (hdr_flat),
    .body_flat_o(body_flat)
  );

  bch_par_net #(
    .DATA_BITS(HDR_DBITS),
    .PAR_BITS (PAR_BITS),
    .POLY_REFL(POLY_REFL)
  ) hdr_par_i (
    .data_i(hdr_flat),
    .par_o (hdr_par)
  );

  for (genvar n = 0; n < SUB_COUNT; n++) begin : g_sub
    logic [SUB_DBITS-1:0] sub_data;
    logic [PAR_BITS-1:0]  sub_par;

    assign sub_data = body_flat[n*SUB_DBITS +: SUB_DBITS];

    bch_par_net #(
      .DATA_BITS(SUB_DBITS),
      .PAR_BITS (PAR_BITS),
      .POLY_REFL(POLY_REFL)
    ) sub_par_i (
      .data_i(sub_data),
      .par_o (sub_par)
    );

    assign sub_word[n*SUB_W +: SUB_W] = {sub_par, sub_data};
  end

  aux_tx_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_fire),
    .slot_i   (vsync_strobe),
    .take_i   (out_ready),
    .busy_o   (seq_busy),
    .capture_o(capture),
    .valid_o  (seq_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      sub_q <= '0;
    end else if (capture) begin
      hdr_q <= {hdr_par, hdr_flat};
      sub_q <= sub_word;
    end
  end

  assign busy      = seq_busy;
  assign wr_ready  = !seq_busy;
  assign out_valid = seq_valid;
  assign out_hdr   = hdr_q;
  assign out_sub   = sub_q;

endmodule

// File: rtl/aux_ecc_packer_chk.sv
module aux_ecc_packer_chk #(
  parameter int HDR_W     = 32,
  parameter int SUB_W     = 64,
  parameter int SUB_COUNT = 4,
  parameter int PAR_BITS  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       arm,
  input logic                       vsync_strobe,
  input logic                       busy,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [HDR_W-1:0]           out_hdr,
  input logic [SUB_COUNT*SUB_W-1:0] out_sub
);

  AST_ARM_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !busy) |=> busy); // R3

  AST_VALID_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(vsync_strobe)); // R5

  AST_IDLE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && vsync_strobe) |=> !out_valid); // R5

  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy); // R9

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr) && $stable(out_sub))); // R9

  AST_HANDOFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && !busy)); // R9

  AST_HDR_ZERO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_hdr[HDR_W-PAR_BITS-1:0] == '0)) |-> (out_hdr[HDR_W-1 -: PAR_BITS] == '0)); // R10

  for (genvar n = 0; n < SUB_COUNT; n++) begin : g_zero
    AST_SUB_ZERO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_sub[n*SUB_W +: SUB_W-PAR_BITS] == '0))
        |-> (out_sub[n*SUB_W+SUB_W-1 -: PAR_BITS] == '0)); // R10
  end

endmodule

bind aux_ecc_packer aux_ecc_packer_chk #(
  .HDR_W    (HDR_W),
  .SUB_W    (SUB_W),
  .SUB_COUNT(SUB_COUNT),
  .PAR_BITS (PAR_BITS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm         (arm),
  .vsync_strobe(vsync_strobe),
  .busy        (busy),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_hdr     (out_hdr),
  .out_sub     (out_sub)
);

// File: tb/aux_ecc_packer_tb_top.sv
`timescale 1ns/1ps
module aux_ecc_packer_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [5:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         arm = 1'b0;
  logic         busy;
  logic         vsync_strobe = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_hdr;
  logic [255:0] out_sub;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aux_ecc_packer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .arm(arm), .busy(busy),
    .vsync_strobe(vsync_strobe), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_sub(out_sub)
  );

  // ---------------- reference model ----------------
  logic [7:0]   mem [36];
  bit           m_busy, m_armed, m_valid;
  logic [31:0]  m_hdr;
  logic [255:0] m_sub;

  function automatic logic [7:0] ref_par(input logic [7:0] q[$]);
    bit bits[$];
    int s = 0;
    foreach (q[i]) for (int k = 0; k < 8; k++) bits.push_back(q[i][k]);
    while (bits.size() > 0) begin
      bit d = bits.pop_front();
      bit f = d ^ bit'(s & 1);
      s = s >> 1;
      if (f) s = s ^ 131;
    end
    return 8'(s);
  endfunction

  task automatic model_release();
    logic [7:0] qh[$];
    qh = {mem[0], mem[1], mem[2]};
    m_hdr = {ref_par(qh), mem[2], mem[1], mem[0]};
    for (int n = 0; n < 4; n++) begin
      logic [7:0] qs[$];
      for (int k = 0; k < 7; k++) begin
        qs.push_back(mem[4 + 7*n + k]);
        m_sub[64*n + 8*k +: 8] = mem[4 + 7*n + k];
      end
      m_sub[64*n + 56 +: 8] = ref_par(qs);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = '0;
      m_busy = 0; m_armed = 0; m_valid = 0; m_hdr = '0; m_sub = '0;
    end else if (m_valid && out_ready) begin
      m_valid = 0; m_busy = 0;
    end else if (m_armed && vsync_strobe) begin
      model_release();
      m_valid = 1; m_armed = 0;
    end else if (!m_busy) begin
      if (wr_valid && (wr_addr <= 2 || (wr_addr >= 4 && wr_addr <= 31)))
        mem[wr_addr] = wr_data;
      if (arm) begin m_busy = 1; m_armed = 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy === m_busy, "R3 busy", 256'(busy), 256'(m_busy));
      chk(wr_ready === !m_busy, "R4 wr_ready", 256'(wr_ready), 256'(!m_busy));
      chk(out_valid === m_valid, "R5 out_valid", 256'(out_valid), 256'(m_valid));
      if (m_valid) begin
        chk(out_hdr === m_hdr, "R6 header word", 256'(out_hdr), 256'(m_hdr));
        chk(out_sub === m_sub, "R7 subpacket words", out_sub, m_sub);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    wr_valid = 1; wr_addr = 6'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pulse_arm();
    arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic pulse_vsync();
    vsync_strobe = 1; @(negedge clk); vsync_strobe = 0;
  endtask

  task automatic take();
    out_ready = 1; @(negedge clk); out_ready = 0;
    chk(!out_valid && !busy, "R9 handoff release", 256'({out_valid, busy}), 256'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    repeat (4) @(negedge clk);
    chk(!busy && !out_valid && wr_ready, "R1 reset flags", 256'({busy, out_valid, wr_ready}), 256'(1));
    chk(out_hdr == '0 && out_sub == '0, "R1 reset words", out_sub, '0);
    rst_n = 1;
    @(negedge clk);

    // idle strobe has no effect
    pulse_vsync();
    chk(!out_valid && !busy, "R5 idle strobe", 256'({out_valid, busy}), 256'(0));

    // all-zero packet
    pulse_arm();
    chk(busy, "R3 busy after arm", 256'(busy), 256'(1));
    pulse_vsync();
    chk(out_valid, "R5 valid one cycle after strobe", 256'(out_valid), 256'(1));
    chk(out_hdr[31:24] == 8'h00, "R10 zero header parity", 256'(out_hdr[31:24]), 256'(0));
    for (int n = 0; n < 4; n++)
      chk(out_sub[64*n+56 +: 8] == 8'h00, "R10 zero subpacket parity", 256'(out_sub[64*n+56 +: 8]), 256'(0));
    take();

    // all-ones, every slot written (unused slots ignored)
    for (int a = 0; a < 36; a++) wr(a, 8'hFF);
    pulse_arm();
    pulse_vsync();
    q = {8'hFF, 8'hFF, 8'hFF};
    chk(out_hdr == {ref_par(q), 24'hFFFFFF}, "R8 all-ones header", 256'(out_hdr), 256'({ref_par(q), 24'hFFFFFF}));
    q = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    chk(out_sub[63:0] == {ref_par(q), 56'hFFFFFFFFFFFFFF}, "R10 all-ones subpacket",
        256'(out_sub[63:0]), 256'({ref_par(q), 56'hFFFFFFFFFFFFFF}));
    take();

    // pattern, writes and arm while busy, back-pressure
    for (int a = 0; a < 36; a++) wr(a, a * 37 + 5);
    wr(3, 8'h11);
    pulse_arm();
    wr(4, 8'hAA);
    wr(0, 8'h55);
    pulse_arm();
    pulse_vsync();
    chk(out_sub[7:0] == 8'(4 * 37 + 5), "R7 checksum byte untouched", 256'(out_sub[7:0]), 256'(8'(4*37+5)));
    chk(out_hdr[7:0] == 8'(5), "R4 busy write ignored", 256'(out_hdr[7:0]), 256'(5));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid, "R9 valid held under stall", 256'(out_valid), 256'(1));
    end
    take();

    // arm and strobe together: strobe ignored, next strobe releases
    wr(10, 8'h3C);
    arm = 1; vsync_strobe = 1;
    @(negedge clk);
    arm = 0; vsync_strobe = 0;
    chk(!out_valid && busy, "R5 strobe with arm ignored", 256'({out_valid, busy}), 256'(1));
    pulse_vsync();
    chk(out_valid, "R5 later strobe releases", 256'(out_valid), 256'(1));
    take();

    // random packets, random addresses including unused ones (R2)
    for (int p = 0; p < 6; p++) begin
      for (int w = 0; w < 50; w++) wr($urandom_range(63), $urandom_range(255));
      pulse_arm();
      repeat ($urandom_range(3)) @(negedge clk);
      pulse_vsync();
      repeat ($urandom_range(4)) @(negedge clk);
      take();
    end

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule